// File: doc/BRIEF.md
# Parity-Protected Two-Way Read-Only Cache

This block is a small set-associative read cache with two ways per set. Each stored tag and each stored data word carries one even-parity bit, written when a line is filled. A lookup reads the whole indexed set and checks every granule of every valid way. A clean hit is answered in the cycle after the request is accepted, so the parity logic adds no delay. A miss sends a one-cycle line request to a lower memory. When the line returns, the cache writes it and replays the original lookup.

When any granule of a valid way in the indexed set fails its parity check, the controller does not try to find the faulty way. It stalls the requester and invalidates both ways of that set. It then bumps an error counter, raises a sticky flag, fetches the wanted line again and replays the access. A fault-injection input flips one stored bit so that this recovery path can be exercised.

The controller has five states:
- `S_IDLE`: ready for a request. It goes to `S_LOOKUP` when a request is accepted.
- `S_LOOKUP`: checks the set. It returns to `S_IDLE` on a clean hit, goes to `S_SCRUB` on a parity error, and goes to `S_FETCH` on a clean miss.
- `S_SCRUB`: invalidates both ways, then goes to `S_FETCH`.
- `S_FETCH`: issues the line request, then goes to `S_WAIT`.
- `S_WAIT`: holds until the line arrives, writes it, and goes back to `S_LOOKUP` for the replay.

Top module: `pcache_top`

## Requirements
- R1: While `rst_n` is low and after it is released, `req_ready` is 1, `rsp_valid` and `fill_req_valid` are 0, `err_count` is 0, `err_sticky` is 0 and every line is invalid.
- R2: A request accepted on a clock edge with `req_valid` and `req_ready` both high that hits a clean line has `rsp_valid` high in the very next cycle. `rsp_data` then holds the word selected by `req_addr[OFF_W-1:0]`. Address layout: {tag, set index, word offset}, with the offset in the low bits.
- R3: On a clean miss, `fill_req_valid` is high for exactly one cycle, with `fill_req_addr` equal to the request address without its offset bits. `req_ready` stays low until the answer. When `fill_rsp_valid` arrives, the line (word k in bits `[k*WORD_W +: WORD_W]`) is written and the access is replayed and answered with the requested word.
- R4: The fill goes to the first invalid way of the set, checking way 0 first. If both ways are valid, it goes to the way named by a per-set round-robin pointer, and after each fill the pointer names the other way.
- R5: The parity bit of each tag (TAG_W bits) and of each data word (WORD_W bits) makes the granule's ones count even. A lookup checks all granules of the valid ways of the set only. Faults in invalid ways are not checked, and fault-free traffic never counts an error.
- R6: On a parity error the controller invalidates both ways of the set, adds 1 to `err_count`, and sets `err_sticky` until reset. It then refetches the requested line and returns the correct word.
- R7: A parity error in either valid way forces recovery even when the other way hits.
- R8: A cycle with `inj_valid` high flips bit `inj_bit` of granule `inj_gran` in way `inj_way` of set `inj_set`. Granule 0 is the tag and granule k is data word k-1. The parity bit sits at position TAG_W or WORD_W. A bit index beyond the granule, or a granule number above WORDS, changes nothing.
- R9: If a fill writes the same set and way in the same cycle as an injection, the fill wins and the line is stored clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | ADDR_W | Word address {tag, set, offset} |
| req_ready | output | 1 | Controller idle, request accepted |
| rsp_valid | output | 1 | Response word valid |
| rsp_data | output | WORD_W | Response word |
| fill_req_valid | output | 1 | One-cycle line request to lower memory |
| fill_req_addr | output | ADDR_W-OFF_W | Line address |
| fill_rsp_valid | input | 1 | Line returned |
| fill_rsp_data | input | WORDS*WORD_W | Returned line, word k at k*WORD_W |
| inj_valid | input | 1 | Flip one stored bit this cycle |
| inj_set | input | IDX_W | Injection set |
| inj_way | input | 1 | Injection way |
| inj_gran | input | GS_W | Granule: 0 tag, k data word k-1 |
| inj_bit | input | IB_W | Bit within granule |
| err_count | output | CNT_W | Recovery events |
| err_sticky | output | 1 | Any recovery since reset |

## Verification
A line fill and a fault injection can hit the same stored entry in the same cycle. The bench provokes this by having its lower-memory model raise an injection aimed at the victim way together with the returned line. It judges the outcome by replaying the access: it must hit in one cycle with the error count unchanged. A parity error in one way and a tag hit in the other also land in one lookup. The bench creates this by corrupting the non-hitting way. It then requires a long latency, a counted error, the correct word, and a later miss on the corrupted line.

// File: rtl/pcache_pkg.sv
package pcache_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOKUP,
        S_SCRUB,
        S_FETCH,
        S_WAIT
    } pc_state_e;

endpackage

// File: rtl/pcache_store.sv
// Tag, data and valid arrays for both ways. Parity is generated on fill,
// single-bit faults are applied by the injection port.
module pcache_store #(
    parameter int SETS   = 16,
    parameter int WORDS  = 4,
    parameter int WORD_W = 20,
    parameter int TAG_W  = 31,
    parameter int IB_W   = 5,
    localparam int IDX_W = $clog2(SETS),
    localparam int TG    = TAG_W + 1,
    localparam int DG    = WORD_W + 1,
    localparam int LB    = WORDS * DG,
    localparam int GS_W  = $clog2(WORDS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [IDX_W-1:0]          rd_set,
    output logic [1:0]                rd_valid,
    output logic [2*TG-1:0]           rd_tags,
    output logic [2*LB-1:0]           rd_lines,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_set,
    input  logic                      wr_way,
    input  logic [TAG_W-1:0]          wr_tag,
    input  logic [WORDS*WORD_W-1:0]   wr_line,
    input  logic                      inv_en,
    input  logic [IDX_W-1:0]          inv_set,
    input  logic                      inj_en,
    input  logic [IDX_W-1:0]          inj_set,
    input  logic                      inj_way,
    input  logic [GS_W-1:0]           inj_gran,
    input  logic [IB_W-1:0]           inj_bit
);

    logic [TG-1:0] tag_q  [SETS][2];
    logic [LB-1:0] line_q [SETS][2];
    logic [1:0]    val_q  [SETS];

    logic [TG-1:0] tag_enc;
    logic [TG-1:0] tag_mask;
    logic [LB-1:0] line_enc;
    logic [LB-1:0] line_mask;

    // even parity: stored bit equals XOR of payload
    assign tag_enc = {^wr_tag, wr_tag};

    always_comb begin
        line_enc = '0;
        for (int k = 0; k < WORDS; k++) begin
            line_enc[k*DG +: DG] = {^wr_line[k*WORD_W +: WORD_W],
                                    wr_line[k*WORD_W +: WORD_W]};
        end
    end

    // shifts past the granule width yield an empty mask
    always_comb begin
        tag_mask  = '0;
        line_mask = '0;
        if (inj_gran == '0) begin
            tag_mask = TG'(1) << inj_bit;
        end
        for (int k = 0; k < WORDS; k++) begin
            if (inj_gran == GS_W'(k + 1)) begin
                line_mask[k*DG +: DG] = DG'(1) << inj_bit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                val_q[s] <= '0;
                for (int w = 0; w < 2; w++) begin
                    tag_q[s][w]  <= '0;
                    line_q[s][w] <= '0;
                end
            end
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < 2; w++) begin
                    if (wr_en && wr_set == IDX_W'(s) && wr_way == w[0]) begin
                        tag_q[s][w]  <= tag_enc;
                        line_q[s][w] <= line_enc;
                        val_q[s][w]  <= 1'b1;
                    end else begin
                        if (inj_en && inj_set == IDX_W'(s) && inj_way == w[0]) begin
                            tag_q[s][w]  <= tag_q[s][w] ^ tag_mask;
                            line_q[s][w] <= line_q[s][w] ^ line_mask;
                        end
                        if (inv_en && inv_set == IDX_W'(s)) begin
                            val_q[s][w] <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    assign rd_valid = val_q[rd_set];
    assign rd_tags  = {tag_q[rd_set][1], tag_q[rd_set][0]};
    assign rd_lines = {line_q[rd_set][1], line_q[rd_set][0]};

endmodule

// File: rtl/pcache_way_check.sv
// Per-way tag compare, parity check over all granules, and word select.
module pcache_way_check #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 20,
    parameter int TAG_W  = 31,
    localparam int OFF_W = $clog2(WORDS),
    localparam int TG    = TAG_W + 1,
    localparam int DG    = WORD_W + 1,
    localparam int LB    = WORDS * DG
) (
    input  logic              valid,
    input  logic [TG-1:0]     tag_g,
    input  logic [LB-1:0]     line_g,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [OFF_W-1:0]  word_sel,
    output logic              hit,
    output logic              perr,
    output logic [WORD_W-1:0] word
);

    logic bad;

    always_comb begin
        bad = ^tag_g;
        for (int k = 0; k < WORDS; k++) begin
            bad = bad | (^line_g[k*DG +: DG]);
        end
        perr = valid & bad;
        hit  = valid && (tag_g[TAG_W-1:0] == req_tag);
    end

    always_comb begin
        word = '0;
        for (int k = 0; k < WORDS; k++) begin
            if (word_sel == OFF_W'(k)) begin
                word = line_g[k*DG +: WORD_W];
            end
        end
    end

endmodule

// File: rtl/pcache_ctrl.sv
// Lookup / scrub / fetch / wait sequencer.
module pcache_ctrl
    import pcache_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic any_hit,
    input  logic any_err,
    input  logic fill_rsp_valid,
    output logic req_ready,
    output logic cap_en,
    output logic rsp_valid,
    output logic fill_req_valid,
    output logic wr_en,
    output logic inv_en,
    output logic err_evt
);

    pc_state_e state_q;
    pc_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_LOOKUP;
            S_LOOKUP: begin
                if (any_err)      state_d = S_SCRUB;
                else if (any_hit) state_d = S_IDLE;
                else              state_d = S_FETCH;
            end
            S_SCRUB:  state_d = S_FETCH;
            S_FETCH:  state_d = S_WAIT;
            S_WAIT:   if (fill_rsp_valid) state_d = S_LOOKUP;
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        req_ready      = 1'b0;
        cap_en         = 1'b0;
        rsp_valid      = 1'b0;
        fill_req_valid = 1'b0;
        wr_en          = 1'b0;
        inv_en         = 1'b0;
        err_evt        = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
                cap_en    = req_valid;
            end
            S_LOOKUP: begin
                rsp_valid = any_hit && !any_err;
                err_evt   = any_err;
            end
            S_SCRUB:  inv_en         = 1'b1;
            S_FETCH:  fill_req_valid = 1'b1;
            S_WAIT:   wr_en          = fill_rsp_valid;
            default: ;
        endcase
    end

endmodule

// File: rtl/pcache_top.sv
module pcache_top #(
    parameter int SETS   = 16,
    parameter int WORDS  = 4,
    parameter int WORD_W = 20,
    parameter int TAG_W  = 31,
    parameter int CNT_W  = 8,
    localparam int IDX_W  = $clog2(SETS),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W,
    localparam int LINE_W = WORDS * WORD_W,
    localparam int GS_W   = $clog2(WORDS + 1),
    localparam int IB_W   = $clog2(((TAG_W > WORD_W) ? TAG_W : WORD_W) + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    output logic                    req_ready,
    output logic                    rsp_valid,
    output logic [WORD_W-1:0]       rsp_data,
    output logic                    fill_req_valid,
    output logic [ADDR_W-OFF_W-1:0] fill_req_addr,
    input  logic                    fill_rsp_valid,
    input  logic [LINE_W-1:0]       fill_rsp_data,
    input  logic                    inj_valid,
    input  logic [IDX_W-1:0]        inj_set,
    input  logic                    inj_way,
    input  logic [GS_W-1:0]         inj_gran,
    input  logic [IB_W-1:0]         inj_bit,
    output logic [CNT_W-1:0]        err_count,
    output logic                    err_sticky
);

    localparam int TG = TAG_W + 1;
    localparam int LB = WORDS * (WORD_W + 1);

    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  cur_set;
    logic [TAG_W-1:0]  cur_tag;
    logic [OFF_W-1:0]  cur_off;

    logic [1:0]        rd_valid;
    logic [2*TG-1:0]   rd_tags;
    logic [2*LB-1:0]   rd_lines;
    logic [1:0]        way_hit;
    logic [1:0]        way_err;
    logic [WORD_W-1:0] way_word [2];

    logic cap_en, wr_en, inv_en, err_evt;
    logic victim;
    logic [SETS-1:0] rr_q;

    assign cur_set       = addr_q[OFF_W +: IDX_W];
    assign cur_tag       = addr_q[ADDR_W-1 -: TAG_W];
    assign cur_off       = addr_q[OFF_W-1:0];
    assign fill_req_addr = addr_q[ADDR_W-1:OFF_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (cap_en) begin
            addr_q <= req_addr;
        end
    end

    pcache_store #(
        .SETS(SETS), .WORDS(WORDS), .WORD_W(WORD_W), .TAG_W(TAG_W), .IB_W(IB_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_set(cur_set), .rd_valid(rd_valid), .rd_tags(rd_tags), .rd_lines(rd_lines),
        .wr_en(wr_en), .wr_set(cur_set), .wr_way(victim), .wr_tag(cur_tag),
        .wr_line(fill_rsp_data),
        .inv_en(inv_en), .inv_set(cur_set),
        .inj_en(inj_valid), .inj_set(inj_set), .inj_way(inj_way),
        .inj_gran(inj_gran), .inj_bit(inj_bit)
    );

    for (genvar g = 0; g < 2; g++) begin : g_way
        pcache_way_check #(
            .WORDS(WORDS), .WORD_W(WORD_W), .TAG_W(TAG_W)
        ) u_chk (
            .valid(rd_valid[g]),
            .tag_g(rd_tags[g*TG +: TG]),
            .line_g(rd_lines[g*LB +: LB]),
            .req_tag(cur_tag),
            .word_sel(cur_off),
            .hit(way_hit[g]),
            .perr(way_err[g]),
            .word(way_word[g])
        );
    end

    assign rsp_data = way_hit[1] ? way_word[1] : way_word[0];

    // empty way first (way 0 preferred), otherwise the round-robin pointer
    always_comb begin
        if (!rd_valid[0])      victim = 1'b0;
        else if (!rd_valid[1]) victim = 1'b1;
        else                   victim = rr_q[cur_set];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (wr_en) begin
            rr_q[cur_set] <= ~victim;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_count  <= '0;
            err_sticky <= 1'b0;
        end else if (err_evt) begin
            err_count  <= err_count + 1'b1;
            err_sticky <= 1'b1;
        end
    end

    pcache_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid),
        .any_hit(|way_hit),
        .any_err(|way_err),
        .fill_rsp_valid(fill_rsp_valid),
        .req_ready(req_ready),
        .cap_en(cap_en),
        .rsp_valid(rsp_valid),
        .fill_req_valid(fill_req_valid),
        .wr_en(wr_en),
        .inv_en(inv_en),
        .err_evt(err_evt)
    );

endmodule

// File: rtl/pcache_sva.sv
module pcache_sva #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             fill_req_valid,
    input logic [CNT_W-1:0] err_count,
    input logic             err_sticky
);

    AST_RSP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R2

    AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid |=> !fill_req_valid); // R3

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R3

    AST_RSP_NOT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !fill_req_valid); // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != $past(err_count)) |-> (err_count == CNT_W'($past(err_count) + 1'b1))); // R6

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky); // R6

    AST_CNT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != '0) |-> err_sticky); // R6

endmodule

bind pcache_top pcache_sva #(.CNT_W(CNT_W)) u_sva (
    .clk(clk),
    .rst_n(rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .fill_req_valid(fill_req_valid),
    .err_count(err_count),
    .err_sticky(err_sticky)
);

// File: tb/sim_pcache_top.sv
module sim_pcache_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [36:0] req_addr;
    logic        req_ready;
    logic        rsp_valid;
    logic [19:0] rsp_data;
    logic        fill_req_valid;
    logic [34:0] fill_req_addr;
    logic        fill_rsp_valid;
    logic [79:0] fill_rsp_data;
    logic        inj_valid;
    logic [3:0]  inj_set;
    logic        inj_way;
    logic [2:0]  inj_gran;
    logic [4:0]  inj_bit;
    logic [7:0]  err_count;
    logic        err_sticky;

    always #10 clk = ~clk;

    pcache_top u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
        .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data),
        .inj_valid(inj_valid), .inj_set(inj_set), .inj_way(inj_way),
        .inj_gran(inj_gran), .inj_bit(inj_bit),
        .err_count(err_count), .err_sticky(err_sticky)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic logic [19:0] memw(input logic [34:0] la, input int k);
        logic [34:0] t;
        t = la * 35'd5 + 35'(k) * 35'd977 + 35'd12345;
        return t[19:0];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // set 3 walk: A=tag1, B=tag2, C=tag3; then set 15 and set 0
    localparam int NV = 15;
    localparam logic [36:0] VA [NV] = '{
        {31'd1, 4'd3, 2'd1},            // A miss -> way0
        {31'd1, 4'd3, 2'd2},            // A hit
        {31'd2, 4'd3, 2'd0},            // B miss -> way1
        {31'd1, 4'd3, 2'd0},            // A hit
        {31'd2, 4'd3, 2'd3},            // B hit
        {31'd3, 4'd3, 2'd1},            // C miss -> way0 (rr), evicts A
        {31'd1, 4'd3, 2'd3},            // A miss -> way1, evicts B
        {31'd3, 4'd3, 2'd2},            // C hit
        {31'd2, 4'd3, 2'd1},            // B miss -> way0, evicts C
        {31'd3, 4'd3, 2'd0},            // C miss -> way1, evicts A
        {31'd1, 4'd3, 2'd2},            // A miss -> way0
        {31'h7FFFFFFF, 4'd15, 2'd3},    // top set, all-ones tag
        {31'h7FFFFFFF, 4'd15, 2'd0},
        {31'd0, 4'd0, 2'd0},            // bottom set, zero tag
        {31'd0, 4'd0, 2'd3}
    };
    localparam bit VM [NV] = '{1, 0, 1, 0, 0, 1, 1, 0, 1, 1, 1, 1, 0, 1, 0};

    // lower memory model, optionally injecting in the fill cycle
    logic [34:0] last_la;
    bit          arm = 0;
    logic [3:0]  arm_set;
    logic        arm_way;
    logic [2:0]  arm_gran;
    logic [4:0]  arm_bit;

    initial begin
        fill_rsp_valid = 1'b0;
        fill_rsp_data  = '0;
        last_la        = '0;
        forever begin
            @(negedge clk);
            if (fill_req_valid) begin
                last_la = fill_req_addr;
                @(negedge clk);
                @(negedge clk);
                fill_rsp_valid = 1'b1;
                for (int k = 0; k < 4; k++) fill_rsp_data[k*20 +: 20] = memw(last_la, k);
                if (arm) begin
                    inj_valid = 1'b1; inj_set = arm_set; inj_way = arm_way;
                    inj_gran  = arm_gran; inj_bit = arm_bit;
                end
                @(negedge clk);
                fill_rsp_valid = 1'b0;
                if (arm) inj_valid = 1'b0;
            end
        end
    end

    task automatic do_req(input logic [36:0] a, output logic [19:0] d,
                          output int lat, output bit leak);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        lat  = 1;
        leak = 0;
        while (!rsp_valid && lat < 100) begin
            if (req_ready) leak = 1;
            @(negedge clk);
            lat++;
        end
        d = rsp_data;
    endtask

    task automatic run_chk(input string req, input logic [36:0] a, input bit exp_miss);
        logic [19:0] d;
        int lat;
        bit leak;
        do_req(a, d, lat, leak);
        chk({req, " data"}, 64'(d), 64'(memw(a[36:2], int'(a[1:0]))));
        chk({req, " miss/hit latency"}, 64'(lat > 1), 64'(exp_miss));
        if (!exp_miss) chk({req, " R2 one-cycle hit"}, 64'(lat), 64'd1);
        if (exp_miss) begin
            chk({req, " R3 fill address"}, 64'(last_la), 64'(a[36:2]));
            chk({req, " R3 stall while busy"}, 64'(leak), 64'd0);
        end
    endtask

    task automatic inject(input logic [3:0] s, input logic w, input logic [2:0] g,
                          input logic [4:0] b);
        @(negedge clk);
        inj_valid = 1'b1; inj_set = s; inj_way = w; inj_gran = g; inj_bit = b;
        @(negedge clk);
        inj_valid = 1'b0;
    endtask

    localparam logic [36:0] F = {31'd7, 4'd5, 2'd1};
    localparam logic [36:0] G = {31'd8, 4'd5, 2'd2};
    localparam logic [36:0] H = {31'd9, 4'd12, 2'd3};

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
        inj_valid = 1'b0; inj_set = '0; inj_way = 1'b0; inj_gran = '0; inj_bit = '0;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", 64'(req_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", 64'(req_ready), 64'd1);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 fill_req_valid", 64'(fill_req_valid), 64'd0);
        chk("R1 err_count", 64'(err_count), 64'd0);
        chk("R1 err_sticky", 64'(err_sticky), 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_chk(VM[i] ? "R3/R4 table miss" : "R2/R4 table hit", VA[i], VM[i]);
        end
        chk("R5 clean traffic count", 64'(err_count), 64'd0);
        chk("R5 clean traffic flag", 64'(err_sticky), 64'd0);

        // set 5: F in way0, G in way1
        run_chk("R3 F first", F, 1);
        run_chk("R4 G second way", G, 1);
        run_chk("R2 F resident", F, 0);
        // data fault in way1 (G word 2), lookup of F hits way0
        inject(4'd5, 1'b1, 3'd3, 5'd4);
        run_chk("R7 error beats hit", F, 1);
        chk("R6 count after data fault", 64'(err_count), 64'd1);
        chk("R6 sticky after data fault", 64'(err_sticky), 64'd1);
        run_chk("R6 other way invalidated", G, 1);
        chk("R6 one event only", 64'(err_count), 64'd1);

        // F now way0, G way1: flip tag parity bit (position 31) of way0
        inject(4'd5, 1'b0, 3'd0, 5'd31);
        run_chk("R8 tag parity bit fault", G, 1);
        chk("R8 count after tag fault", 64'(err_count), 64'd2);

        // G now way0, way1 invalid; out-of-range faults change nothing
        inject(4'd5, 1'b0, 3'd1, 5'd25);
        inject(4'd5, 1'b0, 3'd5, 5'd0);
        run_chk("R8 out-of-range ignored", G, 0);
        chk("R8 count unchanged", 64'(err_count), 64'd2);

        // fault in invalid way1 is not checked
        inject(4'd5, 1'b1, 3'd2, 5'd0);
        run_chk("R5 invalid way unchecked", G, 0);
        chk("R5 count unchanged", 64'(err_count), 64'd2);

        // fill and injection on the same entry in the same cycle
        arm = 1; arm_set = 4'd12; arm_way = 1'b0; arm_gran = 3'd1; arm_bit = 5'd3;
        run_chk("R9 fill with injection", H, 1);
        arm = 0;
        run_chk("R9 line stored clean", H, 0);
        chk("R9 count unchanged", 64'(err_count), 64'd2);
        chk("R6 sticky held", 64'(err_sticky), 64'd1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule